// File: doc/BRIEF.md
# Segmented DAC Code Decoder

This block turns a 12-bit straight-binary sample into the switch-control words of a segmented current-steering converter. The sample splits into three parts. The five upper bits become a 31-line unary code of equal-weight coarse segments. The four middle bits become a 15-line unary code of fine segments, each worth one sixteenth of a coarse segment. The three lowest bits pass through as binary-weighted controls. Each current element has a switch that steers it to one of two outputs. The block therefore drives a true word for the first output and the bitwise complement of that word for the second.

Samples arrive on a valid/ready stream. A sample transfers on a rising edge where `in_valid` and `in_ready` are both high. The decoded words appear on the outputs right after that edge, from registers, so the outputs do not glitch. `in_ready` is the inverse of `sleep`. While `sleep` is high the block applies back-pressure. The upstream source must hold its sample until ready returns, and the outputs keep their last value. The block has no buffer. When `in_valid` is low on an edge, nothing transfers and the outputs hold. `sleep` must be driven high to take effect, so a low level means normal operation.

Top module: `seg_dac_decoder`

## Requirements
- R1: A sample that transfers on a rising edge (`in_valid` and `in_ready` both high) appears decoded on every switch output right after that edge. The outputs do not change at any other time except on reset.
- R2: The number of set lines in `sw_a_msb` equals the value of `in_code[11:7]`. The set lines are 0 to k-1, filling from the lowest index.
- R3: The number of set lines in `sw_a_mid` equals the value of `in_code[6:3]`. The set lines are 0 to k-1, filling from the lowest index.
- R4: `sw_a_lsb` equals `in_code[2:0]`, with bit 2 weighted 4, bit 1 weighted 2 and bit 0 weighted 1.
- R5: Every B line is the complement of the matching A line: `sw_b_msb == ~sw_a_msb`, `sw_b_mid == ~sw_a_mid` and `sw_b_lsb == ~sw_a_lsb`.
- R6: Code 4095 sets every A line and clears every B line. Code 0 clears every A line and sets every B line.
- R7: While `sleep` is high, `in_ready` is low and the outputs hold, whatever `in_code` and `in_valid` do.
- R8: When `sleep` falls, the first rising edge with `in_valid` high loads the sample present at that edge.
- R9: Reset is synchronous and active low. A rising edge with `rst_n` low clears all A lines and sets all B lines. Lowering `rst_n` between edges changes nothing.
- R10: A rising edge with `in_valid` low leaves the outputs unchanged.
- R11: For every code, the weighted sum of the A lines equals the code: set coarse lines × 128 + set fine lines × 8 + `sw_a_lsb`. No line is high in both A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | High: refuse samples and hold the outputs |
| in_valid | input | 1 | Sample on `in_code` is valid |
| in_ready | output | 1 | Block accepts a sample on this edge (inverse of `sleep`) |
| in_code | input | 12 | Straight-binary sample, bit 11 most significant |
| sw_a_msb | output | 31 | Coarse unary switch lines, first output |
| sw_a_mid | output | 15 | Fine unary switch lines, first output |
| sw_a_lsb | output | 3 | Binary-weighted switch lines, first output |
| sw_b_msb | output | 31 | Coarse switch lines, second output (complement) |
| sw_b_mid | output | 15 | Fine switch lines, second output (complement) |
| sw_b_lsb | output | 3 | Binary-weighted switch lines, second output (complement) |

## Verification
The hardest property to reach from the ports is that the weighted sum of the switch lines matches the code at every one of the 4096 codes. An error in a single comparator of a unary decoder shows up only at the one boundary code where that line switches. The bench therefore streams every code in ascending order and checks the weighted sum and the complement after each transfer, so every carry from the binary tail into the fine segment, and from the fine into the coarse segment, is covered. Sleep, idle and reset behaviour are then driven directly, with a differing sample presented, so that any leak into the outputs is visible.

// File: rtl/seg_pkg.sv
package seg_pkg;
  // Default split of the sample word into segments
  localparam int unsigned SEG_DATA_W = 12;
  localparam int unsigned SEG_MSB_W  = 5;
  localparam int unsigned SEG_MID_W  = 4;

  // Number of unary lines needed for a field of the given width
  function automatic int unsigned unary_lines(input int unsigned w);
    return (1 << w) - 1;
  endfunction
endpackage

// File: rtl/seg_thermo_dec.sv
module seg_thermo_dec #(
  parameter int unsigned IN_W  = 4,
  localparam int unsigned LINES = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  val,
  output logic [LINES-1:0] lines
);
  // Line i is set when the field value exceeds i: fill from index 0 up
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = (int'(val) > i);
  end

  // R2/R3: lines form a contiguous run from bit 0 whose length is the value
  always_comb begin
    if (!$isunknown(val)) begin
      a_r2_thermo_fill: assert (((lines & (lines + LINES'(1))) == '0) &&
                                ($countones(lines) == int'(val)))
        else $error("unary decode shape or count wrong");
    end
  end
endmodule

// File: rtl/seg_switch_reg.sv
module seg_switch_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d_true,
  output logic [W-1:0] q_a,
  output logic [W-1:0] q_b
);
  // Separate true and complement registers, both loaded on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_a <= '0;
      q_b <= '1;
    end else if (load) begin
      q_a <= d_true;
      q_b <= ~d_true;
    end
  end

  // R5: each element steered to exactly one output
  a_r5_complementary: assert property (@(posedge clk) disable iff (!rst_n)
    (q_a ^ q_b) == '1)
    else $error("A and B words not complementary");

  // R7/R10: no load means no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(q_a) && $stable(q_b)))
    else $error("switch word changed without a load");
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
  import seg_pkg::*;
#(
  parameter int unsigned DATA_W = SEG_DATA_W,
  parameter int unsigned MSB_W  = SEG_MSB_W,
  parameter int unsigned MID_W  = SEG_MID_W,
  localparam int unsigned LSB_W     = DATA_W - MSB_W - MID_W,
  localparam int unsigned MSB_LINES = (1 << MSB_W) - 1,
  localparam int unsigned MID_LINES = (1 << MID_W) - 1,
  localparam int unsigned TOT_W     = MSB_LINES + MID_LINES + LSB_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sleep,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DATA_W-1:0]    in_code,
  output logic [MSB_LINES-1:0] sw_a_msb,
  output logic [MID_LINES-1:0] sw_a_mid,
  output logic [LSB_W-1:0]     sw_a_lsb,
  output logic [MSB_LINES-1:0] sw_b_msb,
  output logic [MID_LINES-1:0] sw_b_mid,
  output logic [LSB_W-1:0]     sw_b_lsb
);
  logic [MSB_LINES-1:0] msb_lines;
  logic [MID_LINES-1:0] mid_lines;
  logic [TOT_W-1:0]     word_true;
  logic [TOT_W-1:0]     word_a;
  logic [TOT_W-1:0]     word_b;
  logic                 take;

  // Sleep is the only source of back-pressure
  assign in_ready = !sleep;
  assign take     = in_valid && in_ready;

  seg_thermo_dec #(.IN_W(MSB_W)) u_msb_dec (
    .val   (in_code[DATA_W-1 -: MSB_W]),
    .lines (msb_lines)
  );

  seg_thermo_dec #(.IN_W(MID_W)) u_mid_dec (
    .val   (in_code[LSB_W +: MID_W]),
    .lines (mid_lines)
  );

  // Coarse lines on top, fine lines in the middle, binary tail at the bottom
  assign word_true = {msb_lines, mid_lines, in_code[LSB_W-1:0]};

  seg_switch_reg #(.W(TOT_W)) u_sw_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (take),
    .d_true (word_true),
    .q_a    (word_a),
    .q_b    (word_b)
  );

  assign sw_a_lsb = word_a[LSB_W-1:0];
  assign sw_a_mid = word_a[LSB_W +: MID_LINES];
  assign sw_a_msb = word_a[LSB_W+MID_LINES +: MSB_LINES];
  assign sw_b_lsb = word_b[LSB_W-1:0];
  assign sw_b_mid = word_b[LSB_W +: MID_LINES];
  assign sw_b_msb = word_b[LSB_W+MID_LINES +: MSB_LINES];

  // R1/R2: coarse line count follows the accepted sample's upper field
  a_r2_msb_count: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ($countones(sw_a_msb) == int'($past(in_code[DATA_W-1 -: MSB_W]))))
    else $error("coarse line count wrong");

  // R3: fine line count follows the middle field
  a_r3_mid_count: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ($countones(sw_a_mid) == int'($past(in_code[LSB_W +: MID_W]))))
    else $error("fine line count wrong");

  // R4: binary tail passes straight through
  a_r4_tail: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (sw_a_lsb == $past(in_code[LSB_W-1:0])))
    else $error("binary tail wrong");

  // R11: weighted sum of A lines reproduces the accepted code
  a_r11_weight: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (($countones(sw_a_msb) * (1 << (MID_W + LSB_W)) +
               $countones(sw_a_mid) * (1 << LSB_W) + int'(sw_a_lsb))
              == int'($past(in_code))))
    else $error("weighted sum differs from code");

  // R7: sleeping freezes every output
  a_r7_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(sw_a_msb) && $stable(sw_a_mid) && $stable(sw_a_lsb)))
    else $error("output moved during sleep");

  // R9: reset edge steers everything to the B side
  a_r9_reset_b: assert property (@(posedge clk)
    !rst_n |=> ((sw_a_msb == '0) && (sw_a_mid == '0) && (sw_a_lsb == '0) &&
                (&sw_b_msb) && (&sw_b_mid) && (&sw_b_lsb)))
    else $error("reset did not steer to B");
endmodule

// File: tb/test_seg_dac_decoder.sv
`timescale 1ns/1ps
module test_seg_dac_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_code = '0;
  logic [30:0] sw_a_msb, sw_b_msb;
  logic [14:0] sw_a_mid, sw_b_mid;
  logic [2:0]  sw_a_lsb, sw_b_lsb;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seg_dac_decoder i_seg_dac_decoder (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .in_valid(in_valid),
    .in_ready(in_ready), .in_code(in_code),
    .sw_a_msb(sw_a_msb), .sw_a_mid(sw_a_mid), .sw_a_lsb(sw_a_lsb),
    .sw_b_msb(sw_b_msb), .sw_b_mid(sw_b_mid), .sw_b_lsb(sw_b_lsb)
  );

  // Vectors: {code[11:0], coarse count[4:0], fine count[3:0], tail[2:0]}
  localparam logic [23:0] VEC [10] = '{
    {12'h000, 5'd0,  4'd0,  3'd0},
    {12'hFFF, 5'd31, 4'd15, 3'd7},
    {12'h800, 5'd16, 4'd0,  3'd0},
    {12'h07F, 5'd0,  4'd15, 3'd7},
    {12'h080, 5'd1,  4'd0,  3'd0},
    {12'h078, 5'd0,  4'd15, 3'd0},
    {12'h005, 5'd0,  4'd0,  3'd5},
    {12'hABC, 5'd21, 4'd7,  3'd4},
    {12'h7FF, 5'd15, 4'd15, 3'd7},
    {12'h123, 5'd2,  4'd4,  3'd3}
  };

  // Compare all six outputs against a fill-from-zero expectation
  task automatic chk_words(input string req, input int kmsb, input int kmid,
                           input logic [2:0] tail);
    logic [30:0] em;
    logic [14:0] ed;
    em = 31'((64'd1 << kmsb) - 64'd1);
    ed = 15'((64'd1 << kmid) - 64'd1);
    total++;
    if (sw_a_msb !== em || sw_a_mid !== ed || sw_a_lsb !== tail ||
        sw_b_msb !== ~em || sw_b_mid !== ~ed || sw_b_lsb !== ~tail) begin
      bad++;
      $display("FAIL %s: got A=%h/%h/%h B=%h/%h/%h expected A=%h/%h/%h B=%h/%h/%h",
               req, sw_a_msb, sw_a_mid, sw_a_lsb, sw_b_msb, sw_b_mid, sw_b_lsb,
               em, ed, tail, ~em, ~ed, ~tail);
    end
  endtask

  task automatic chk_code(input string req, input logic [11:0] c);
    chk_words(req, int'(c[11:7]), int'(c[6:3]), c[2:0]);
  endtask

  // Present a sample at a falling edge; it transfers at the next rising edge
  task automatic send(input logic [11:0] c);
    @(negedge clk);
    in_code = c;
    in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 30000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk_words("R9 reset state", 0, 0, 3'd0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R6: vector table
    foreach (VEC[i]) begin
      send(VEC[i][23:12]);
      chk_words("R1 R2 R3 R4 R6 vector", int'(VEC[i][11:7]), int'(VEC[i][6:3]),
                VEC[i][2:0]);
    end

    // R11 R5: every code in ascending order, weighted sum and complement
    for (int c = 0; c < 4096; c++) begin
      int sum;
      send(12'(c));
      sum = $countones(sw_a_msb) * 128 + $countones(sw_a_mid) * 8 + int'(sw_a_lsb);
      total++;
      if (sum != c || (sw_a_msb & sw_b_msb) != '0 || (sw_a_mid & sw_b_mid) != '0 ||
          (sw_a_lsb & sw_b_lsb) != '0 || (sw_a_msb | sw_b_msb) != '1 ||
          (sw_a_mid | sw_b_mid) != '1 || (sw_a_lsb | sw_b_lsb) != '1) begin
        bad++;
        $display("FAIL R11 R5: got sum=%0d A=%h/%h/%h B=%h/%h/%h expected sum=%0d complementary",
                 sum, sw_a_msb, sw_a_mid, sw_a_lsb, sw_b_msb, sw_b_mid, sw_b_lsb, c);
      end
    end

    // R10: valid low, new code presented, outputs hold
    send(12'hABC);
    @(negedge clk);
    in_valid = 1'b0;
    in_code = 12'h123;
    repeat (2) @(negedge clk);
    chk_code("R10 idle hold", 12'hABC);

    // R7: sleep refuses samples and holds outputs
    sleep = 1'b1;
    in_valid = 1'b1;
    in_code = 12'h7FF;
    #1;
    total++;
    if (in_ready !== 1'b0) begin
      bad++;
      $display("FAIL R7: got in_ready=%b expected 0", in_ready);
    end
    repeat (3) @(negedge clk);
    chk_code("R7 sleep hold", 12'hABC);

    // R8: release sleep, next edge loads the sample present
    sleep = 1'b0;
    #1;
    total++;
    if (in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R8: got in_ready=%b expected 1", in_ready);
    end
    @(negedge clk);
    chk_code("R8 load after wake", 12'h7FF);

    // R9: reset is synchronous, then clears to B side
    send(12'hFFF);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #2;
    chk_code("R9 sync no early clear", 12'hFFF);
    @(negedge clk);
    chk_words("R9 reset clears", 0, 0, 3'd0);
    rst_n = 1'b1;

    // R6: full scale after reset
    send(12'hFFF);
    chk_code("R6 full scale", 12'hFFF);
    send(12'h000);
    chk_code("R6 zero scale", 12'h000);

    done = 1'b1;
    finish_run();
  end
endmodule